// File: doc/BRIEF.md
# Cumulative Distribution Accumulator

This block turns a histogram held in an on-block memory of 2^ADDR_W words (1024 x 24 bits by default) into its cumulative distribution, in place. After a histogram has been installed through the preload port, the user pulls the active-low run input low. The block then walks every address from 0 upwards with its own counter. At each address it adds the stored word to a running total, writes that total back to the same location and presents it as a beat on the output stream. When the walk has finished, the memory holds the cumulative distribution and the done flag is raised.

While the run input is high, the walk continues but acts only as a reader. Each beat carries the stored word unchanged, nothing is written back, and the running total is held. Any new falling edge on the run input abandons the current walk and starts again from address 0 with a zero total. A walk with only a one-cycle low pulse on the run input is therefore a non-destructive dump of the memory.

Both data interfaces are valid/ready. An output beat stays on `out_data`/`out_addr` until `out_ready` accepts it, and the whole walk pauses while it waits. `pre_ready` is high only while no walk is in progress. A preload word offered while `pre_ready` is low is not taken.

Top module: `cdf_sweeper`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `done` are 0 and `pre_ready` is 1.
- R2: After a walk starts, beats carry addresses 0, 1, 2, … in steps of one per accepted beat up to 2^ADDR_W-1. No further beat appears until the next falling edge of `run_n`.
- R3: If `run_n` is first sampled low at clock edge k, having been high at edge k-1, the beat for address 0 is presented right after edge k+3. The run level that governs the beat presented after edge n is the one sampled at edge n-2.
- R4: A beat governed by a low run level outputs (running total + stored word), writes that value back to the same address and makes it the new running total.
- R5: A beat governed by a high run level outputs the stored word, leaves the memory unchanged and keeps the running total.
- R6: The running total is DATA_W bits wide and wraps modulo 2^DATA_W.
- R7: A falling edge of `run_n` during a walk discards the entry in flight (it is neither written nor output), zeroes the total and restarts at address 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_addr` hold and the walk pauses. No beat is lost or repeated.
- R9: `done` rises with the presentation of the beat for the last address and stays high until the next walk starts.
- R10: A preload word is written at `pre_addr` exactly when `pre_valid` and `pre_ready` are both high. `pre_ready` is 0 from the start of a walk until its last write, and a word offered then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_n | input | 1 | Run control, active low; a falling edge starts a walk |
| pre_valid | input | 1 | Preload word offered |
| pre_ready | output | 1 | Preload accepted (high when no walk is running) |
| pre_addr | input | ADDR_W | Preload address |
| pre_data | input | DATA_W | Preload word |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | DATA_W | Running total, or the stored word on read-only beats |
| out_addr | output | ADDR_W | Address the beat belongs to |
| done | output | 1 | Walk has written its last address |

## Verification
The hardest case to reach from the ports is a restart that lands while an entry is between the memory read and its write-back. A read-modify-write with a wrong address or total that slips through there would corrupt only a few words. The stimulus reaches this state by holding run low for a few hundred cycles, raising it for a short stretch so that read-only beats flow, and then lowering it again. A later read-only dump then exposes every stored word. A second hard case is a walk under irregular back-pressure, driven from a pseudo-random ready pattern, so that stalls fall on every stage of the pipeline.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  // walk state of the address counter
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_e;
endpackage

// File: rtl/cdf_run_sync.sv
module cdf_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic run_n,
  output logic restart,
  output logic mod_now
);
  logic run_q, run_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      run_qq <= 1'b1;
    end else begin
      run_q  <= run_n;
      run_qq <= run_q;
    end
  end

  // a sampled falling edge restarts the walk; the sampled level tags entries
  assign restart = !run_q && run_qq;
  assign mod_now = !run_q;
endmodule

// File: rtl/cdf_addr_gen.sv
module cdf_addr_gen
  import cdf_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic              issue,
  output logic [ADDR_W-1:0] addr,
  output logic              active
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  sweep_e st_q;

  assign active = (st_q == SW_RUN);
  assign issue  = active && advance && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SW_IDLE;
      addr <= '0;
    end else if (restart) begin
      st_q <= SW_RUN;
      addr <= '0;
    end else if (issue) begin
      if (addr == LAST) st_q <= SW_IDLE;   // hold at the last address
      else              addr <= addr + 1'b1;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (addr != LAST) |=> addr == $past(addr) + 1'b1);

  assert_hold_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (addr == LAST) |=> !active && (addr == LAST));

  assert_restart_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> active && (addr == '0));
endmodule

// File: rtl/cdf_ram.sv
module cdf_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)    mem[wr_addr] <= wr_data;
    if (rd_en) rd_data      <= mem[rd_addr];
  end
endmodule

// File: rtl/cdf_accum.sv
module cdf_accum #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              mod_now,
  input  logic [DATA_W-1:0] rd_data,
  output logic              advance,
  output logic              inflight,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  // read stage: entry whose word is arriving from memory
  logic              s1_vld, s1_mod;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] sum_q, sum_nx;

  assign advance  = !out_valid || out_ready;
  assign inflight = s1_vld;
  assign sum_nx   = sum_q + rd_data;          // wraps modulo 2^DATA_W

  assign wr_en   = s1_vld && s1_mod && advance && !restart;
  assign wr_addr = s1_addr;
  assign wr_data = sum_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_mod    <= 1'b0;
      s1_addr   <= '0;
      sum_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
      done      <= 1'b0;
    end else if (restart) begin
      s1_vld    <= 1'b0;
      s1_mod    <= 1'b0;
      s1_addr   <= '0;
      sum_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
      done      <= 1'b0;
    end else if (advance) begin
      s1_vld    <= issue;
      s1_mod    <= mod_now;
      s1_addr   <= issue_addr;
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_addr <= s1_addr;
        out_data <= s1_mod ? sum_nx : rd_data;
        if (s1_mod)          sum_q <= sum_nx;
        if (s1_addr == LAST) done  <= 1'b1;
      end
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !restart |=> out_valid && $stable(out_data) && $stable(out_addr));

  assert_done_at_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> out_valid && (out_addr == LAST));

  assert_restart_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid && !done && !inflight);
endmodule

// File: rtl/cdf_sweeper.sv
module cdf_sweeper #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_n,
  input  logic              pre_valid,
  output logic              pre_ready,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              done
);
  logic              restart, mod_now, advance, issue, active, inflight;
  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] rd_data;
  logic              sw_we, ram_we, pre_we;
  logic [ADDR_W-1:0] sw_addr, ram_waddr;
  logic [DATA_W-1:0] sw_data, ram_wdata;

  cdf_run_sync u_run (
    .clk, .rst_n, .run_n, .restart, .mod_now
  );

  cdf_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rst_n, .restart, .advance, .issue, .addr(cnt), .active
  );

  cdf_accum #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk, .rst_n, .restart, .issue, .issue_addr(cnt), .mod_now, .rd_data,
    .advance, .inflight, .wr_en(sw_we), .wr_addr(sw_addr), .wr_data(sw_data),
    .out_valid, .out_ready, .out_data, .out_addr, .done
  );

  // preload only while no walk owns the memory
  assign pre_ready = !(active || inflight);
  assign pre_we    = pre_valid && pre_ready;
  assign ram_we    = sw_we || pre_we;
  assign ram_waddr = sw_we ? sw_addr : pre_addr;
  assign ram_wdata = sw_we ? sw_data : pre_data;

  cdf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk, .rd_en(issue), .rd_addr(cnt), .rd_data,
    .we(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata)
  );

  assert_preload_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |-> !pre_ready);
endmodule

// File: tb/test_cdf_sweeper.sv
`timescale 1ns/1ps
module test_cdf_sweeper;
  localparam int AW = 10;
  localparam int DW = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_n = 1'b1;
  logic pre_valid = 1'b0;
  logic pre_ready;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [AW-1:0] out_addr;
  logic done;

  always #2.5 clk = ~clk;

  cdf_sweeper #(.ADDR_W(AW), .DATA_W(DW)) i_cdf_sweeper (
    .clk, .rst_n, .run_n, .pre_valid, .pre_ready, .pre_addr, .pre_data,
    .out_valid, .out_ready, .out_data, .out_addr, .done
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_sum = '0;
  int  m_next = 0;
  bit  m_sweep = 0;
  bit  m_done = 0;
  bit  held = 0;
  bit  r0 = 1, r1 = 1, r2 = 1;   // run_n at edges ec, ec-1, ec-2
  string phase = "R5";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    r2 = r1; r1 = r0; r0 = run_n;
  end

  // beat monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      held = 0;
    end else begin
      if (r1 == 1'b0 && r2 == 1'b1) begin   // restart at this edge (R7)
        m_next = 0; m_sum = '0; m_done = 0; m_sweep = 1; held = 0;
      end
      if (out_valid && !held) begin
        if (!m_sweep) begin
          chk("R2 unexpected beat", 32'(out_addr), 32'hFFFF_FFFF);
        end else begin
          logic [DW-1:0] exp_d;
          string tag;
          tag = phase;
          if (!r2) begin
            logic [DW:0] wide;
            wide = {1'b0, m_sum} + {1'b0, m_mem[m_next]};
            if (wide[DW]) tag = "R6";
            m_sum = wide[DW-1:0];
            m_mem[m_next] = m_sum;
            exp_d = m_sum;
          end else begin
            exp_d = m_mem[m_next];
          end
          chk("R2 address", 32'(out_addr), 32'(m_next));
          chk(tag, 32'(out_data), 32'(exp_d));
          if (m_next == DEPTH-1) begin m_done = 1; m_sweep = 0; end
          m_next++;
        end
      end
      chk("R9 done", 32'(done), 32'(m_done));
      held = out_valid && !out_ready;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic preload(input int a, input logic [DW-1:0] d);
    pre_valid = 1'b1; pre_addr = AW'(a); pre_data = d;
    chk("R10 ready when idle", 32'(pre_ready), 32'd1);
    step();
    pre_valid = 1'b0;
    m_mem[a] = d;
  endtask

  task automatic start_walk(input bit modify);
    run_n = 1'b1; step(); step();
    run_n = 1'b0; step();                 // sampled low at edge k
    if (!modify) run_n = 1'b1;
    step(); step();                       // k+1, k+2
    chk("R3 no beat before k+3", 32'(out_valid), 32'd0);
    step();                               // k+3
    chk("R3 first beat at k+3", 32'(out_valid), 32'd1);
    chk("R3 first address", 32'(out_addr), 32'd0);
  endtask

  task automatic wait_done(input bit stall);
    int guard = 0;
    logic [15:0] lfsr = 16'hACE1;
    while (!done && guard < 6000) begin
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[3];
      end
      step();
      guard++;
    end
    out_ready = 1'b1;
    chk("R9 walk completes", 32'(done), 32'd1);
    repeat (30) step();                   // no stray beats after the last address (R2)
    chk("R9 done holds", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 pre_ready after reset", 32'(pre_ready), 32'd1);

    // R10: install a histogram with large words to force wrap (R6)
    for (int i = 0; i < DEPTH; i++)
      preload(i, (i % 61 == 0) ? DW'(24'hE00000 + i) : DW'((i * i * 3 + i) & 12'hFFF));

    // R5: read-only walk shows the preload unchanged
    phase = "R5";
    start_walk(1'b0);
    wait_done(1'b0);

    // R4/R6: cumulative walk; a preload offered mid-walk must be refused (R10)
    phase = "R4";
    start_walk(1'b1);
    repeat (100) step();
    pre_valid = 1'b1; pre_addr = AW'(900); pre_data = 24'h123456;
    chk("R10 ready low during walk", 32'(pre_ready), 32'd0);
    step();
    pre_valid = 1'b0;
    wait_done(1'b0);

    // R5: dump shows the cumulative result in place and address 900 untouched
    phase = "R5";
    start_walk(1'b0);
    wait_done(1'b0);

    // R7: read-only stretch then a restart with entries in flight
    phase = "R7";
    start_walk(1'b1);
    repeat (300) step();
    run_n = 1'b1;
    repeat (40) step();
    run_n = 1'b0;
    step(); step();
    chk("R7 done cleared by restart", 32'(done), 32'd0);
    wait_done(1'b0);
    phase = "R5";
    start_walk(1'b0);
    wait_done(1'b0);

    // R8: cumulative walk and a dump under irregular back-pressure
    phase = "R8";
    start_walk(1'b1);
    wait_done(1'b1);
    start_walk(1'b0);
    wait_done(1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule